// File: doc/BRIEF.md
# Self-Aligning Bit Error Counter

The block compares a reference bit stream, as it was sent, with the bit stream that comes back from a link whose latency is not known in advance. The reference stream goes through a tapped delay line. After a start pulse, the block tries one candidate delay after another, from a lower bound up to an upper bound. It keeps the first candidate under which the delayed reference agrees with the received stream. From then on it counts the compared bits and the mismatched bits.

A bit strobe marks the cycles that carry a new bit pair. No other cycle has any effect. A candidate is judged over a fixed trial window of compared bits. Any mismatch in the window rejects the candidate and moves to the next one. If the whole range fails, a fail flag is raised and the sweep starts again from the lower bound.

The controller is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_TRIAL` is the sweep. It goes to itself on a rejected window, or on a wrap at the upper bound, which raises the fail flag.
- `ST_LOCKED` is entered from `ST_TRIAL` after a clean window.
- A start pulse moves any state to `ST_TRIAL`.

Top module: `lat_sweep_bert`

## Requirements
- R1: After reset, `locked`, `sweep_fail`, `bit_cnt`, `err_cnt` and `locked_dly` are all 0.
- R2: A cycle with `start` high has these effects:
  - it captures `dly_min` and `dly_max`;
  - it clears `locked`, `sweep_fail`, `bit_cnt` and `err_cnt`;
  - it sets the candidate to `dly_min` in the next cycle;
  - it skips the comparison of any strobe in the same cycle.
- R3: Under candidate delay d (0 to DEPTH-1), the `rx_bit` of a strobe is compared with the `tx_bit` given d strobes earlier. With d = 0, it is compared with the `tx_bit` of the same strobe.
- R4: A candidate is accepted after TRIAL_LEN (64) compared strobes with no mismatch. `locked` rises in the cycle after the last of those strobes.
- R5: A window that holds any mismatch rejects the candidate. The candidate then rises by one.
- R6: A strobe is not compared while fewer than d tx bits have been strobed since reset.
- R7: A window rejected at a candidate equal to or above the captured maximum has two effects. It sets `sweep_fail`, and it returns the candidate to the captured minimum while the sweep goes on. `sweep_fail` stays set until the next start or a lock.
- R8: `locked_dly` always shows the current candidate. Once `locked` is set, `locked` and `locked_dly` hold until the next start.
- R9: While locked, every strobe adds one to `bit_cnt`, and every mismatching strobe also adds one to `err_cnt`. Both results are visible in the cycle after the strobe. Neither counter moves while unlocked.
- R10: Cycles with `bit_vld` low change neither the counters nor the delay history, whatever `tx_bit` and `rx_bit` are.
- R11: `bit_cnt` and `err_cnt` stop at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Clears results and begins a new sweep |
| bit_vld | input | 1 | Strobe: tx_bit and rx_bit carry a new bit pair |
| tx_bit | input | 1 | Reference (sent) bit |
| rx_bit | input | 1 | Received bit |
| dly_min | input | DLY_W | Lowest candidate delay, in strobes |
| dly_max | input | DLY_W | Highest candidate delay, in strobes |
| locked_dly | output | DLY_W | Current candidate delay; the found latency once locked |
| locked | output | 1 | Candidate accepted; counting active |
| sweep_fail | output | 1 | Whole range failed at least once since start |
| bit_cnt | output | CNT_W | Compared bits since lock (saturating) |
| err_cnt | output | CNT_W | Mismatched bits since lock (saturating) |

## Verification
Every result is registered. `locked`, `sweep_fail`, `locked_dly` and both counters therefore change at the clock edge that takes the deciding strobe or start, and they are visible one cycle after that input is applied. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check falls exactly one edge after its cause. Lock and fail times are predicted as exact strobe counts:
- (d + 64) strobes when the sweep starts right after reset;
- 64 strobes for each rejected candidate before the matching one;
- 64 × (range size) strobes until the fail flag rises.

Each of these is checked in the cycle before it is due and in the cycle it is due. Expected counter values count only the strobes applied while `locked` was already seen high.

// File: rtl/lsbc_pkg.sv
package lsbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRIAL  = 2'd1,
        ST_LOCKED = 2'd2
    } sweep_state_t;
endpackage

// File: rtl/ref_delay_line.sv
module ref_delay_line #(
    parameter int DEPTH = 64,
    localparam int DLY_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             tx_bit,
    input  logic [DLY_W-1:0] tap_sel,
    output logic             ref_bit,
    output logic             tap_ready
);
    localparam logic [DLY_W-1:0] FILL_MAX = DLY_W'(DEPTH - 1);

    logic [DEPTH-2:0] hist;
    logic [DLY_W-1:0] fill;
    logic [DEPTH-1:0] taps;

    // history of past strobed tx bits, newest in bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
        end else if (bit_vld) begin
            hist <= {hist[DEPTH-3:0], tx_bit};
            if (fill != FILL_MAX) begin
                fill <= fill + DLY_W'(1);
            end
        end
    end

    always_comb begin
        taps      = {hist, tx_bit};
        ref_bit   = taps[tap_sel];
        tap_ready = (fill >= tap_sel);
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
    import lsbc_pkg::*;
#(
    parameter int DLY_W     = 6,
    parameter int TRIAL_LEN = 64,
    localparam int WIN_W    = $clog2(TRIAL_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_vld,
    input  logic             tap_ready,
    input  logic             mism,
    input  logic [DLY_W-1:0] lo_in,
    input  logic [DLY_W-1:0] hi_in,
    output logic [DLY_W-1:0] cand,
    output logic             locked,
    output logic             fail,
    output logic             count_en
);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(TRIAL_LEN - 1);

    sweep_state_t     state, state_nx;
    logic [WIN_W-1:0] win;
    logic             miss;
    logic [DLY_W-1:0] lo_q, hi_q;
    logic             cmp_now, win_end, win_bad;

    always_comb begin
        cmp_now = (state == ST_TRIAL) && bit_vld && tap_ready && !start;
        win_end = cmp_now && (win == WIN_LAST);
        win_bad = miss || mism;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_TRIAL;
            ST_TRIAL:  if (start) state_nx = ST_TRIAL;
                       else if (win_end && !win_bad) state_nx = ST_LOCKED;
            ST_LOCKED: if (start) state_nx = ST_TRIAL;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // sweep datapath: bounds, candidate, window tally, fail flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            cand <= '0;
            win  <= '0;
            miss <= 1'b0;
            fail <= 1'b0;
        end else if (start) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
            cand <= lo_in;
            win  <= '0;
            miss <= 1'b0;
            fail <= 1'b0;
        end else if (cmp_now) begin
            if (win_end) begin
                win  <= '0;
                miss <= 1'b0;
                if (!win_bad) begin
                    fail <= 1'b0;
                end else if (cand >= hi_q) begin
                    cand <= lo_q;
                    fail <= 1'b1;
                end else begin
                    cand <= cand + DLY_W'(1);
                end
            end else begin
                win  <= win + WIN_W'(1);
                miss <= win_bad;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        locked   = (state == ST_LOCKED);
        count_en = (state == ST_LOCKED) && bit_vld && !start;
    end
endmodule

// File: rtl/lat_sweep_bert.sv
module lat_sweep_bert #(
    parameter int DEPTH     = 64,
    parameter int TRIAL_LEN = 64,
    parameter int CNT_W     = 32,
    localparam int DLY_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_vld,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic [DLY_W-1:0] dly_min,
    input  logic [DLY_W-1:0] dly_max,
    output logic [DLY_W-1:0] locked_dly,
    output logic             locked,
    output logic             sweep_fail,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] err_cnt
);
    logic ref_bit, tap_ready, mism, count_en;

    ref_delay_line #(.DEPTH(DEPTH)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .tx_bit    (tx_bit),
        .tap_sel   (locked_dly),
        .ref_bit   (ref_bit),
        .tap_ready (tap_ready)
    );

    assign mism = ref_bit ^ rx_bit;

    sweep_ctrl #(.DLY_W(DLY_W), .TRIAL_LEN(TRIAL_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bit_vld   (bit_vld),
        .tap_ready (tap_ready),
        .mism      (mism),
        .lo_in     (dly_min),
        .hi_in     (dly_max),
        .cand      (locked_dly),
        .locked    (locked),
        .fail      (sweep_fail),
        .count_en  (count_en)
    );

    sat_counter #(.W(CNT_W)) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (count_en),
        .cnt   (bit_cnt)
    );

    sat_counter #(.W(CNT_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (count_en && mism),
        .cnt   (err_cnt)
    );
endmodule

// File: rtl/lat_sweep_bert_chk.sv
module lat_sweep_bert_chk #(
    parameter int DLY_W = 6,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             bit_vld,
    input logic [DLY_W-1:0] locked_dly,
    input logic             locked,
    input logic             sweep_fail,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [CNT_W-1:0] err_cnt
);
    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!locked && !sweep_fail && bit_cnt == '0 && err_cnt == '0));

    // R4
    lock_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_vld));

    // R7
    fail_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_fail |-> !locked);

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start) |=> (locked && $stable(locked_dly)));

    // R9
    count_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (bit_cnt == '0));

    // R9
    err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= bit_cnt);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !start) |=> ($stable(bit_cnt) && $stable(err_cnt)));

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&bit_cnt) && !start) |=> (&bit_cnt));
endmodule

bind lat_sweep_bert lat_sweep_bert_chk #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bit_vld    (bit_vld),
    .locked_dly (locked_dly),
    .locked     (locked),
    .sweep_fail (sweep_fail),
    .bit_cnt    (bit_cnt),
    .err_cnt    (err_cnt)
);

// File: tb/tb_lat_sweep_bert.sv
module tb_lat_sweep_bert;
    localparam int DLY_W = 6;
    localparam int SAT_W = 6;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bit_vld = 1'b0;
    logic tx_bit = 1'b0, rx_bit = 1'b0;
    logic [DLY_W-1:0] dly_min = '0, dly_max = '0;
    logic [DLY_W-1:0] locked_dly, s_dly;
    logic locked, sweep_fail, s_locked, s_fail;
    logic [31:0] bit_cnt, err_cnt;
    logic [SAT_W-1:0] s_bits, s_errs;

    int n_chk = 0, n_fail = 0;
    int lat = 40;
    longint exp_bits = 0, exp_errs = 0;
    logic [255:0] txh = '0;

    always #5 clk = ~clk;

    lat_sweep_bert dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .dly_min(dly_min), .dly_max(dly_max),
        .locked_dly(locked_dly), .locked(locked), .sweep_fail(sweep_fail),
        .bit_cnt(bit_cnt), .err_cnt(err_cnt)
    );

    lat_sweep_bert #(.CNT_W(SAT_W)) dut_sat (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(bit_vld),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .dly_min(dly_min), .dly_max(dly_max),
        .locked_dly(s_dly), .locked(s_locked), .sweep_fail(s_fail),
        .bit_cnt(s_bits), .err_cnt(s_errs)
    );

    function automatic longint sat_of(input longint v);
        return (v > 63) ? 63 : v;
    endfunction

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one cycle of stimulus, applied on the falling edge
    task automatic drive(input logic vld, input logic allow_err);
        logic t, r, e;
        @(negedge clk);
        t = 1'($urandom & 1);
        e = allow_err && locked && vld && (($urandom % 32) == 0);
        r = ((lat == 0) ? t : txh[lat-1]) ^ e;
        if (!vld) r = 1'($urandom & 1);
        if (vld && locked) begin
            exp_bits++;
            if (e) exp_errs++;
        end
        tx_bit = t; rx_bit = r; bit_vld = vld; start = 1'b0;
        if (vld) txh = {txh[254:0], t};
    endtask

    task automatic strobes(input int n, input int gap_pct, input logic allow_err);
        int done = 0;
        while (done < n) begin
            logic v;
            v = (($urandom % 100) >= gap_pct);
            drive(v, allow_err);
            if (v) done++;
        end
    endtask

    task automatic do_start(input int lo, input int hi);
        @(negedge clk);
        dly_min = DLY_W'(lo); dly_max = DLY_W'(hi);
        start = 1'b1; bit_vld = 1'b0;
        exp_bits = 0; exp_errs = 0;
        @(negedge clk);
        start = 1'b0;
        chk("R2 locked cleared", locked, 0);
        chk("R2 bit_cnt cleared", bit_cnt, 0);
        chk("R2 err_cnt cleared", err_cnt, 0);
        chk("R2 fail cleared", sweep_fail, 0);
        chk("R2 candidate=min", locked_dly, lo);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        longint b0, e0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 locked", locked, 0);
        chk("R1 fail", sweep_fail, 0);
        chk("R1 bit_cnt", bit_cnt, 0);
        chk("R1 err_cnt", err_cnt, 0);
        chk("R1 locked_dly", locked_dly, 0);
        rst_n = 1'b1;

        // R6 priming right after reset: lock after lat + 64 strobes
        lat = 40;
        do_start(40, 45);
        strobes(103, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R6 not yet locked at 103", locked, 0);
        strobes(1, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R6 R4 locked at 104", locked, 1);
        chk("R3 locked delay", locked_dly, 40);

        // R5 sweep 35..39 rejected, 40 accepted after 384 strobes
        do_start(35, 45);
        strobes(128, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R5 candidate after two windows", locked_dly, 37);
        strobes(255, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R4 not locked at 383", locked, 0);
        strobes(1, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R4 locked at 384", locked, 1);
        chk("R3 R8 locked delay", locked_dly, 40);

        // R9 clean link with random gaps, 22000 bits
        strobes(22000, 25, 1'b0); drive(1'b0, 1'b0);
        chk("R9 bit_cnt clean", bit_cnt, exp_bits);
        chk("R9 expected 22000", exp_bits, 22000);
        chk("R9 err_cnt clean", err_cnt, 0);
        chk("R11 saturated bit_cnt", s_bits, sat_of(exp_bits));
        chk("R8 still locked", locked, 1);

        // R9 injected errors
        do_start(38, 42);
        strobes(3000, 20, 1'b1); drive(1'b0, 1'b0);
        chk("R9 bit_cnt with errors", bit_cnt, exp_bits);
        chk("R9 err_cnt with errors", err_cnt, exp_errs);
        chk("R11 saturated err_cnt", s_errs, sat_of(exp_errs));
        chk("R8 locked delay held", locked_dly, 40);

        // R10 idle cycles with garbage data do nothing
        b0 = bit_cnt; e0 = err_cnt;
        repeat (50) drive(1'b0, 1'b0);
        chk("R10 bit_cnt unchanged", bit_cnt, b0);
        chk("R10 err_cnt unchanged", err_cnt, e0);
        strobes(100, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R10 history intact, no new errors", err_cnt, e0);

        // R7 latency outside range: fail after 11 windows
        lat = 50;
        do_start(35, 45);
        strobes(703, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R7 no fail at 703", sweep_fail, 0);
        strobes(1, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R7 fail at 704", sweep_fail, 1);
        chk("R7 candidate back to min", locked_dly, 35);
        chk("R7 unlocked", locked, 0);
        chk("R9 no counting unlocked", bit_cnt, 0);

        // R3 boundary delays: 0 and DEPTH-1
        lat = 0;
        do_start(0, 0);
        strobes(64, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R3 delay 0 locked", locked, 1);
        chk("R3 delay 0 value", locked_dly, 0);
        lat = 63;
        do_start(63, 63);
        strobes(64, 0, 1'b0); drive(1'b0, 1'b0);
        chk("R3 delay 63 locked", locked, 1);
        chk("R3 delay 63 value", locked_dly, 63);
        strobes(500, 10, 1'b1); drive(1'b0, 1'b0);
        chk("R9 delay 63 errors", err_cnt, exp_errs);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule